// File: doc/BRIEF.md
# Configurable Two-Level AND-OR Logic Array

This block is a sum-of-products logic array whose contents are set at run time. Each of its product terms is the AND of any chosen subset of the true and complemented input variables. Each output is the OR of any chosen subset of those product terms, and an inversion bit for that output can then be applied. Because a term may feed several outputs at once, logic that several functions have in common is built only once. The inversion lets an output be built from the product terms of its complement.

The configuration is one serial bitstream, shifted in one bit per clock while the shift enable is high. The bits collect in a shadow register that the logic does not use. A single-cycle commit pulse then copies the whole shadow into the active map. Loading a new map therefore never shows a half-written map at the outputs. The array evaluates combinationally and, by default, drives the outputs through one register stage.

Top module: `pla_array`

## Requirements
- R1: The default size is 4 inputs, 6 product terms and 3 outputs. With the default registered stage, `dout` shows the function of the `din` value present at a rising edge just after that edge, which is one cycle of latency.
- R2: Each product term can use 2·N_IN literals, namely the true and the complemented form of every input. A term with at least one connected literal is the AND of its connected literals.
- R3: A product term with no connected literal evaluates to 0. A term that connects both forms of the same input also evaluates to 0.
- R4: Any product term can feed any set of outputs, so one term is shared by several outputs.
- R5: An output with no connected product term is 0 before inversion, so it reads 0 with its inversion bit clear and 1 with it set.
- R6: Setting an output's inversion bit gives the complement of the OR of its connected terms.
- R7: The bitstream holds P·2N + P·M + M bits, and the first bit shifted in is stream position 0. Positions 0 to P·2N−1 are the AND connections, term by term starting with term 0. Within a term, the connection for input i in true form is at offset 2i and in complemented form at offset 2i+1. The OR connection of term t to output o is at P·2N + t·M + o. The inversion bit of output o is at P·2N + P·M + o. A 1 means connected or inverted.
- R8: Shifting never changes the outputs. Only a `cfg_commit` pulse replaces the active map. A commit in the same cycle as a shift takes the shadow contents from before that shift.
- R9: A synchronous reset clears the active map, the shadow register and the output stage. All outputs then read 0, and a commit with no shifting since the reset keeps them at 0.
- R10: When loaded with F1 = Σm(2,4,5,7) and F2 = Σm(0,1,2,4,6) over `din[2:0]` (minterm index = `din[2:0]`), plus a third output built from the F1 terms with inversion set, the array reproduces F1, F2 and ¬F1 for all inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shift_en | input | 1 | Shift one configuration bit this cycle |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_commit | input | 1 | Copy the shadow map into the active map |
| din | input | N_IN | Input variables |
| dout | output | N_OUT | Array outputs |

## Verification
The hardest case to reach from the ports is a commit in the same cycle as a shift. Proving that the pre-shift shadow was taken requires a map that is exactly aligned just before that edge, followed by an extra junk bit. The bench shifts a complete stream, then issues the commit together with one more shift, and sweeps every input against the map it expects. Degenerate terms (empty or self-contradictory) seldom arise in random maps. A dedicated map builds them and also tests empty outputs under both polarities. Throughout every load, the bench keeps changing `din` and expects the old map's results.

// File: rtl/pla_pkg.sv
package pla_pkg;

  // total configuration stream length
  function automatic int cfg_bits(int n, int p, int m);
    return p * 2 * n + p * m + m;
  endfunction

  // stream position of literal k of term t (k = 2i true, 2i+1 complement)
  function automatic int and_pos(int n, int t, int k);
    return t * 2 * n + k;
  endfunction

  // stream position of the link from term t to output o
  function automatic int or_pos(int n, int p, int m, int t, int o);
    return p * 2 * n + t * m + o;
  endfunction

  // stream position of the inversion bit of output o
  function automatic int pol_pos(int n, int p, int m, int o);
    return p * 2 * n + p * m + o;
  endfunction

endpackage

// File: rtl/pla_cfg_shadow.sv
module pla_cfg_shadow
  import pla_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_TERM = 6,
  parameter int N_OUT  = 3
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                shift_en,
  input  logic                                shift_bit,
  input  logic                                commit,
  output logic [N_TERM-1:0][2*N_IN-1:0]       and_map,
  output logic [N_TERM-1:0][N_OUT-1:0]        or_map,
  output logic [N_OUT-1:0]                    pol
);
  localparam int LIT = 2 * N_IN;
  localparam int LEN = cfg_bits(N_IN, N_TERM, N_OUT);

  logic [LEN-1:0] shadow_q;
  logic [LEN-1:0] active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (shift_en) shadow_q <= {shadow_q[LEN-2:0], shift_bit};
      if (commit)   active_q <= shadow_q;
    end
  end

  // first bit shifted ends at the MSB: position p sits at LEN-1-p
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    for (genvar k = 0; k < LIT; k++) begin : g_lit
      assign and_map[t][k] = active_q[LEN-1-and_pos(N_IN, t, k)];
    end
    for (genvar o = 0; o < N_OUT; o++) begin : g_link
      assign or_map[t][o] = active_q[LEN-1-or_pos(N_IN, N_TERM, N_OUT, t, o)];
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_pol
    assign pol[o] = active_q[LEN-1-pol_pos(N_IN, N_TERM, N_OUT, o)];
  end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 6
) (
  input  logic [N_IN-1:0]                     x,
  input  logic [N_TERM-1:0][2*N_IN-1:0]       and_map,
  output logic [N_TERM-1:0]                   terms
);
  localparam int LIT = 2 * N_IN;

  logic [LIT-1:0] lit;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit[2*i]   = x[i];
    assign lit[2*i+1] = ~x[i];
  end

  // an unconnected row is disabled rather than constant 1
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    assign terms[t] = (|and_map[t]) & (&(~and_map[t] | lit));
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM  = 6,
  parameter int N_OUT   = 3,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [N_TERM-1:0]                   terms,
  input  logic [N_TERM-1:0][N_OUT-1:0]        or_map,
  input  logic [N_OUT-1:0]                    pol,
  output logic [N_OUT-1:0]                    raw,
  output logic [N_OUT-1:0]                    dout
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_TERM-1:0] col;
    for (genvar t = 0; t < N_TERM; t++) begin : g_col
      assign col[t] = or_map[t][o];
    end
    assign raw[o] = |(col & terms);
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) dout <= '0;
      else     dout <= raw ^ pol;
    end
  end else begin : g_comb
    assign dout = raw ^ pol;
  end

endmodule

// File: rtl/pla_array.sv
module pla_array #(
  parameter int N_IN    = 4,
  parameter int N_TERM  = 6,
  parameter int N_OUT   = 3,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_shift_en,
  input  logic             cfg_bit,
  input  logic             cfg_commit,
  input  logic [N_IN-1:0]  din,
  output logic [N_OUT-1:0] dout
);
  logic [N_TERM-1:0][2*N_IN-1:0] and_map_w;
  logic [N_TERM-1:0][N_OUT-1:0]  or_map_w;
  logic [N_OUT-1:0]              pol_w;
  logic [N_TERM-1:0]             terms_w;
  logic [N_OUT-1:0]              raw_w;

  pla_cfg_shadow #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .shift_en (cfg_shift_en),
    .shift_bit(cfg_bit),
    .commit   (cfg_commit),
    .and_map  (and_map_w),
    .or_map   (or_map_w),
    .pol      (pol_w)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .x      (din),
    .and_map(and_map_w),
    .terms  (terms_w)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT), .REG_OUT(REG_OUT)) u_or (
    .clk   (clk),
    .rst   (rst),
    .terms (terms_w),
    .or_map(or_map_w),
    .pol   (pol_w),
    .raw   (raw_w),
    .dout  (dout)
  );

endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
  parameter int N_IN    = 4,
  parameter int N_TERM  = 6,
  parameter int N_OUT   = 3,
  parameter bit REG_OUT = 1'b1
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          cfg_commit,
  input logic [N_IN-1:0]               din,
  input logic [N_OUT-1:0]              dout,
  input logic [N_TERM-1:0][2*N_IN-1:0] and_map,
  input logic [N_TERM-1:0]             terms,
  input logic [N_OUT-1:0]              raw
);
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    assert_blank_term_low_R3: assert property (@(posedge clk) disable iff (rst)
      (and_map[t] == '0) |-> !terms[t]);
    for (genvar i = 0; i < N_IN; i++) begin : g_in
      assert_contra_term_low_R3: assert property (@(posedge clk) disable iff (rst)
        (and_map[t][2*i] && and_map[t][2*i+1]) |-> !terms[t]);
    end
  end

  assert_no_term_no_sum_R5: assert property (@(posedge clk) disable iff (rst)
    (terms == '0) |-> (raw == '0));

  if (REG_OUT) begin : g_reg
    assert_hold_without_commit_R8: assert property (@(posedge clk) disable iff (rst)
      (!$past(cfg_commit) && $stable(din)) |=> $stable(dout));
    assert_reset_clears_R9: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (dout == '0));
  end
endmodule

bind pla_array pla_array_chk #(
  .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .REG_OUT(REG_OUT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_commit(cfg_commit),
  .din       (din),
  .dout      (dout),
  .and_map   (and_map_w),
  .terms     (terms_w),
  .raw       (raw_w)
);

// File: tb/pla_array_bench.sv
`timescale 1ns/100ps
module pla_array_bench;
  localparam int N = 4;
  localparam int P = 6;
  localparam int M = 3;
  localparam int L = P * 2 * N + P * M + M;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_shift_en = 1'b0;
  logic cfg_bit = 1'b0;
  logic cfg_commit = 1'b0;
  logic [N-1:0] din = '0;
  logic [M-1:0] dout;

  always #2.5 clk = ~clk;

  pla_array u_pla_array (
    .clk(clk), .rst(rst), .cfg_shift_en(cfg_shift_en), .cfg_bit(cfg_bit),
    .cfg_commit(cfg_commit), .din(din), .dout(dout)
  );

  typedef struct { logic [M-1:0] exp; string tag; } item_t;
  item_t q[$];
  int checks = 0;
  int errs = 0;
  bit done = 0;

  logic [L-1:0] model_sh = '0;
  logic [L-1:0] model_act = '0;
  logic [L-1:0] build;

  // stream position p lives at bit L-1-p (R7)
  function automatic logic [M-1:0] model_eval(logic [L-1:0] mp, logic [N-1:0] x);
    logic [M-1:0] r = '0;
    for (int t = 0; t < P; t++) begin
      bit any = 0;
      bit ok = 1;
      for (int i = 0; i < N; i++) begin
        if (mp[L-1-(t*2*N+2*i)])   begin any = 1; ok = ok & x[i];  end
        if (mp[L-1-(t*2*N+2*i+1)]) begin any = 1; ok = ok & ~x[i]; end
      end
      for (int o = 0; o < M; o++)
        if (any && ok && mp[L-1-(P*2*N+t*M+o)]) r[o] = 1'b1;
    end
    for (int o = 0; o < M; o++) r[o] = r[o] ^ mp[L-1-(P*2*N+P*M+o)];
    return r;
  endfunction

  task automatic set_and(int t, int i, bit comp); build[L-1-(t*2*N+2*i+int'(comp))] = 1'b1; endtask
  task automatic set_or(int t, int o);  build[L-1-(P*2*N+t*M+o)] = 1'b1; endtask
  task automatic set_pol(int o);        build[L-1-(P*2*N+P*M+o)] = 1'b1; endtask

  task automatic cyc_x(logic [N-1:0] x, logic en, logic b, logic cm, logic [M-1:0] exp, string tag);
    item_t it;
    @(negedge clk);
    din = x; cfg_shift_en = en; cfg_bit = b; cfg_commit = cm;
    it.exp = exp; it.tag = tag;
    q.push_back(it);
    if (cm) model_act = model_sh;
    if (en) model_sh = {model_sh[L-2:0], b};
  endtask

  task automatic cyc(logic [N-1:0] x, logic en, logic b, logic cm, string tag);
    cyc_x(x, en, b, cm, model_eval(model_act, x), tag);
  endtask

  // full stream, outputs must keep the old map meanwhile (R8), then commit
  task automatic load(logic [L-1:0] s, bit do_commit);
    for (int p = 0; p < L; p++) cyc(N'(p * 5 + 3), 1'b1, s[L-1-p], 1'b0, "R8 shift hold");
    if (do_commit) cyc('0, 1'b0, 1'b0, 1'b1, "R8 commit");
  endtask

  task automatic sweep(string tag);
    for (int v = 0; v < (1 << N); v++) cyc(N'(v), 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cfg_shift_en = 0; cfg_commit = 0;
    model_act = '0; model_sh = '0;
    @(negedge clk);
    checks++;
    if (dout !== '0) begin
      errs++;
      $display("FAIL R9 reset output: actual=%b expected=%b", dout, {M{1'b0}});
    end
    rst = 1'b0;
  endtask

  // monitor: result of a drive appears just after the next rising edge (R1)
  initial begin
    forever begin
      @(posedge clk);
      if (q.size() != 0) begin
        item_t it;
        it = q.pop_front();
        #1;
        checks++;
        if (dout !== it.exp) begin
          errs++;
          $display("FAIL %s: actual=%b expected=%b", it.tag, dout, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL R1 watchdog expired: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    do_reset();
    for (int v = 0; v < 4; v++) cyc_x(N'(v * 3), 1'b0, 1'b0, 1'b0, '0, "R9 cleared map");

    // R10 / R4 / R6: F1 = AB'+AC+A'BC', F2 = C'+A'B', A=din[2] B=din[1] C=din[0]
    build = '0;
    set_and(0, 2, 0); set_and(0, 1, 1);
    set_and(1, 2, 0); set_and(1, 0, 0);
    set_and(2, 2, 1); set_and(2, 1, 0); set_and(2, 0, 1);
    set_and(3, 0, 1);
    set_and(4, 2, 1); set_and(4, 1, 1);
    for (int t = 0; t < 3; t++) begin set_or(t, 0); set_or(t, 2); end
    set_or(3, 1); set_or(4, 1);
    set_pol(2);
    load(build, 1'b1);
    for (int v = 0; v < (1 << N); v++) begin
      logic f1, f2;
      f1 = 8'b1011_0100 >> v[2:0];
      f2 = 8'b0101_0111 >> v[2:0];
      cyc_x(N'(v), 1'b0, 1'b0, 1'b0, {~f1, f2, f1}, "R10 R4 R6 R1 minterm table");
    end

    // R3 / R5: empty term, contradictory term, empty outputs of both polarities
    build = '0;
    set_or(0, 0);
    set_and(1, 0, 0); set_and(1, 0, 1); set_and(1, 2, 0); set_or(1, 0);
    set_and(2, 1, 0);
    set_pol(2);
    load(build, 1'b1);
    for (int v = 0; v < (1 << N); v++)
      cyc_x(N'(v), 1'b0, 1'b0, 1'b0, 3'b100, "R3 R5 degenerate terms");

    // R8: commit in the same cycle as an extra shift takes the aligned map
    build = '0;
    set_and(0, 3, 0); set_or(0, 0); set_or(0, 1);
    set_and(5, 1, 1); set_or(5, 2);
    load(build, 1'b0);
    cyc(N'(9), 1'b1, 1'b1, 1'b1, "R8 commit with shift");
    for (int v = 0; v < (1 << N); v++)
      cyc_x(N'(v), 1'b0, 1'b0, 1'b0, {~v[1], v[3], v[3]}, "R8 pre-shift map");

    // R2 / R4 / R6 / R7: random sparse maps against the reference model
    for (int r = 0; r < 20; r++) begin
      build = '0;
      for (int p = 0; p < L; p++)
        build[L-1-p] = (p < P * 2 * N) ? ($urandom % 5 == 0) : ($urandom % 2 == 1);
      load(build, 1'b1);
      sweep("R2 R4 R6 R7 random map");
    end

    // R9: reset wipes active and shadow; a bare commit keeps outputs at 0
    do_reset();
    cyc_x('1, 1'b0, 1'b0, 1'b1, '0, "R9 commit after reset");
    for (int v = 0; v < (1 << N); v++) cyc_x(N'(v), 1'b0, 1'b0, 1'b0, '0, "R9 shadow cleared");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule